// File: doc/BRIEF.md
# Fully Associative Read Cache with First-In-First-Out Replacement

This block sits between a processor read port and a slow main memory of 32K words of 12 bits. Each entry keeps a whole 15-bit address next to its 12-bit data word, so any entry can hold any memory word. A request is compared with every valid entry at the same moment. On a match the stored word comes back one cycle later. When nothing matches, the block starts a read on the memory side and waits for the memory to answer. It then hands the word to the processor and keeps the address-data pair in one of its entries.

Every entry has a valid bit, and reset clears all of them. Entries are filled in ascending index order. Once every entry is in use, a pointer that moves round the entries picks the next one to overwrite, so the oldest pair is always the one replaced. The processor side uses a valid/ready handshake, and it is held off for as long as a miss is open. The processor never writes through this block.

Top module: `assoc_read_cache`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_req is 0, and no entry is valid, so the first request to any address misses.
- R2: The whole 15-bit request address is the tag. Two addresses that differ only in bit 14 are separate entries, and each returns its own 12-bit word.
- R3: A request accepted when req_valid and req_ready are both 1 at a rising edge, whose address matches a valid entry, gives rsp_valid = 1 with the stored word on rsp_data in the next cycle only. mem_req stays 0.
- R4: An accepted request that misses raises mem_req in the next cycle, with mem_addr equal to the request address. Both stay unchanged until mem_ready is sampled at 1. In the cycle after that, rsp_valid is 1 and rsp_data equals the mem_data that was sampled.
- R5: req_ready is 0 from the cycle after a missing request is accepted until the cycle after the fill. A req_valid driven while req_ready is 0 has no effect: it produces no response and no memory read, either then or afterwards.
- R6: A word brought in by a miss is stored with its address, so a later request to that address hits and returns the same word.
- R7: After reset, misses fill entries 0, 1, 2 and so on in order. No valid entry is overwritten until all ENTRIES entries are valid.
- R8: Once the cache is full, each miss overwrites the oldest fill, in round-robin order. Hits do not change that order: with 8 entries, the ninth distinct miss evicts the first address even if that address hit just before.
- R9: mem_ready has no effect while mem_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor read request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 15 | Word address of the request |
| rsp_valid | output | 1 | One-cycle pulse: rsp_data is valid |
| rsp_data | output | 12 | Returned data word |
| mem_req | output | 1 | Main-memory read pending |
| mem_addr | output | 15 | Address of the pending memory read |
| mem_ready | input | 1 | Memory returns mem_data this cycle |
| mem_data | input | 12 | Word returned by memory |

## Verification
The bench goes after addresses that differ only in their top bit. A design that compared only part of the address would answer one of them with the other's word. It also runs the full-cache sequence in which the oldest entry is hit and then a new miss arrives. An LRU-style design would keep that entry, and a pointer that failed to advance or wrap would evict the wrong one; the hits and misses that follow expose either error. Stray requests while a miss is open, and mem_ready pulses while idle, catch designs that accept or respond when they should not. Random memory latency, checked against a reference model, catches a design that lets mem_addr drift or responds early.

// File: rtl/assoc_read_cache.sv
module assoc_read_cache #(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 12,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_data
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [ADDR_W-1:0]  tag_q [ENTRIES];
  logic [DATA_W-1:0]  dat_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] hit_vec;
  logic [PTR_W-1:0]   fill_ptr;
  logic [DATA_W-1:0]  hit_data;
  logic               busy;

  wire accept = req_valid && req_ready;
  wire fill   = busy && mem_ready;
  wire hit    = |hit_vec;

  assign req_ready = !busy;
  assign mem_req   = busy;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (tag_q[g] == req_addr);
  end

  always_comb begin
    hit_data = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_data = hit_data | dat_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      vld_q     <= '0;
      fill_ptr  <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      mem_addr  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        if (hit) begin
          rsp_valid <= 1'b1;
          rsp_data  <= hit_data;
        end else begin
          busy     <= 1'b1;
          mem_addr <= req_addr;
        end
      end
      if (fill) begin
        busy            <= 1'b0;
        rsp_valid       <= 1'b1;
        rsp_data        <= mem_data;
        vld_q[fill_ptr] <= 1'b1;
        fill_ptr        <= (fill_ptr == LAST) ? '0 : fill_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tag_q[fill_ptr] <= mem_addr;
      dat_q[fill_ptr] <= mem_data;
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R2
  AST_HIT_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit |=> rsp_valid && !mem_req); // R3
  AST_MISS_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !hit |=> mem_req && mem_addr == $past(req_addr) && !rsp_valid); // R4
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr)); // R4
  AST_FILL_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ready |=> rsp_valid && req_ready && rsp_data == $past(mem_data)); // R4
  AST_FILL_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    fill && !(&vld_q) |=> $countones(vld_q) == $countones($past(vld_q)) + 1); // R7
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req && mem_ready |=> !rsp_valid && !mem_req); // R9
endmodule

// File: tb/assoc_read_cache_test.sv
`timescale 1ns/1ps
module assoc_read_cache_test;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, mem_ready = 1'b0;
  logic [14:0] req_addr = '0;
  logic [11:0] mem_data = '0;
  logic req_ready, rsp_valid, mem_req;
  logic [11:0] rsp_data;
  logic [14:0] mem_addr;

  assoc_read_cache #(.ADDR_W(15), .DATA_W(12), .ENTRIES(N)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_data(mem_data));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic        m_vld [N];
  logic [14:0] m_tag [N];
  logic [11:0] m_dat [N];
  int          m_ptr = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual cycles %0d expected below 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [11:0] mem_word(input logic [14:0] a);
    return 12'(a * 37) ^ 12'h5A3 ^ 12'(a >> 9);
  endfunction

  function automatic int lookup(input logic [14:0] a);
    for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == a) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
    end
  endtask

  // kind: 1 must hit, 2 must miss, 0 either (model decides)
  task automatic do_req(input logic [14:0] a, input int kind, input string r);
    int idx;
    @(negedge clk);
    check(!rsp_valid, "R3 pulse", rsp_valid, 0);
    req_valid = 1'b1; req_addr = a;
    idx = lookup(a);
    if (kind == 1) check(idx >= 0, {r, " expected hit"}, idx, 0);
    if (kind == 2) check(idx < 0, {r, " expected miss"}, idx, -1);
    @(negedge clk);
    req_valid = 1'b0;
    if (idx >= 0) begin
      check(rsp_valid && !mem_req, {r, " R3 hit response"}, {rsp_valid, mem_req}, 2);
      check(rsp_data == m_dat[idx], {r, " R3 R6 hit data"}, rsp_data, m_dat[idx]);
    end else begin
      check(mem_req && mem_addr == a, {r, " R4 miss request"}, mem_addr, a);
      check(!req_ready && !rsp_valid, {r, " R5 blocked"}, {req_ready, rsp_valid}, 0);
      for (int w = $urandom_range(0, 3); w > 0; w--) begin
        if ($urandom_range(0, 1) == 1) begin
          req_valid = 1'b1; req_addr = a ^ 15'h0155;
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(mem_req && mem_addr == a, "R4 hold", mem_addr, a);
        check(!rsp_valid && !req_ready, "R5 wait", {rsp_valid, req_ready}, 0);
      end
      mem_ready = 1'b1; mem_data = mem_word(a);
      @(negedge clk);
      mem_ready = 1'b0;
      check(rsp_valid && rsp_data == mem_word(a), {r, " R4 fill data"}, rsp_data, mem_word(a));
      check(req_ready && !mem_req, "R5 released", {req_ready, mem_req}, 2);
      m_vld[m_ptr] = 1'b1; m_tag[m_ptr] = a; m_dat[m_ptr] = mem_word(a);
      m_ptr = (m_ptr + 1) % N;
      @(negedge clk);
      check(!rsp_valid && !mem_req, "R5 stray ignored", {rsp_valid, mem_req}, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req, "R1 reset outputs",
          {req_ready, rsp_valid, mem_req}, 4);
    mem_ready = 1'b1; mem_data = 12'hABC;
    @(negedge clk);
    mem_ready = 1'b0;
    @(negedge clk);
    check(!rsp_valid && !mem_req && req_ready, "R9 idle mem_ready",
          {req_ready, rsp_valid, mem_req}, 4);
    do_req(15'h0001, 2, "R1");
    do_req(15'h4001, 2, "R2");
    do_req(15'h0001, 1, "R2");
    do_req(15'h4001, 1, "R6");
    for (int k = 2; k < N; k++) do_req(15'h1000 + 15'(k), 2, "R7");
    do_req(15'h0001, 1, "R7");
    do_req(15'h4001, 1, "R7");
    for (int k = 2; k < N; k++) do_req(15'h1000 + 15'(k), 1, "R7");
    do_req(15'h0001, 1, "R8");
    do_req(15'h7FFF, 2, "R8");
    do_req(15'h4001, 1, "R8");
    do_req(15'h0001, 2, "R8");
    do_req(15'h4001, 2, "R8");
    do_req(15'h1002, 2, "R8");
    do_req(15'h7FFF, 1, "R8");
    for (int n = 0; n < 300; n++) begin
      int s = $urandom_range(0, 15);
      do_req({s[3], 11'h000, s[2:0]}, 0, "R6");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule